// File: doc/BRIEF.md
# IPv4 Forwarding Header Processor

This block is one stage of a router datapath. Packets arrive on a word bus that carries 64 data bits and an 8-bit control byte per word, with a write strobe and a ready signal that flows back upstream. A packet starts with one or more module-header words, which have a nonzero control byte. These are followed by the Ethernet frame, whose last word again carries a nonzero control byte. The stage stores each packet and parses its Ethernet and IPv4 headers. It validates them, finds the next hop with a longest-prefix table, and resolves the next-hop MAC with an address-resolution table. Packets are then rewritten for forwarding or handed to a CPU port unchanged.

Output ports are numbered so that each network port `p` owns even position `2p` and its CPU companion owns odd position `2p+1`. The chosen destination is written as a one-hot vector into the input-queue module header, which is the header whose control byte is 0xff. Packets that came from a CPU port skip every check and lookup and go straight to the paired network port. Both tables and the per-port MAC addresses are loaded through simple write ports.

Top module: `ipv4_fwd_hdr_proc`

## Requirements
- R1: After reset `in_rdy` is 1 and `out_wr` is 0.
- R2: Every input word leaves in order, and the number of words out equals the number in. Words that are not edited keep their data and control byte. Words are byte-packed big-endian from data word 0: destination MAC, source MAC, ethertype, then the IPv4 header.
- R3: The input-queue module header (control 0xff) carries the input port index in bits [31:16]. On output, bits [63:48] hold the destination as a one-hot vector with exactly one bit set.
- R4: When several prefix entries match the destination IP, the entry with the longest prefix length decides the next hop and the network port. A forwarded packet goes to one-hot bit `2*port`.
- R5: A prefix entry whose next-hop IP is zero means the destination is directly attached, and the destination IP itself is resolved in the address table.
- R6: A forwarded packet gets the resolved MAC as its destination MAC and the output port's own MAC as its source MAC.
- R7: A forwarded packet leaves with TTL reduced by one and a header checksum equal to a full recomputation over the edited header.
- R8: A packet from a network port with TTL 0 or 1 goes, unmodified except for the module header, to the CPU port paired with its input (input `p` goes to one-hot bit `p+1`).
- R9: A packet with a wrong header checksum, a version/length byte other than 0x45, or an ethertype other than 0x0800 goes unmodified to the paired CPU port.
- R10: A packet whose destination MAC differs from its input port's MAC goes unmodified to the paired CPU port.
- R11: A miss in the prefix table or in the address table sends the packet unmodified to the paired CPU port.
- R12: A packet whose input index is odd (a CPU port) goes unmodified to one-hot bit `input-1`, whatever its headers hold.
- R13: A word appears with `out_wr` only in the cycle after `out_rdy` was high. `in_rdy` stays low from the last input word until the packet has fully left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 64 | Input data word |
| in_ctrl | input | 8 | Input control byte |
| in_wr | input | 1 | Input word strobe, only while `in_rdy` |
| in_rdy | output | 1 | Stage can take input words |
| out_data | output | 64 | Output data word |
| out_ctrl | output | 8 | Output control byte |
| out_wr | output | 1 | Output word strobe |
| out_rdy | input | 1 | Downstream permits the next word |
| rt_we | input | 1 | Prefix table write |
| rt_idx | input | 3 | Prefix table entry |
| rt_valid | input | 1 | Entry valid |
| rt_prefix | input | 32 | Prefix value |
| rt_len | input | 6 | Prefix length 0..32 |
| rt_nh | input | 32 | Next-hop IP, zero for direct |
| rt_port | input | 2 | Network port index |
| nb_we | input | 1 | Address table write |
| nb_idx | input | 3 | Address table entry |
| nb_valid | input | 1 | Entry valid |
| nb_ip | input | 32 | Neighbour IP |
| nb_mac | input | 48 | Neighbour MAC |
| pm_we | input | 1 | Port MAC write |
| pm_idx | input | 2 | Network port index |
| pm_mac | input | 48 | Port MAC address |

## Verification
The hardest situation to reach is an exception that is decided late. A packet can pass every header check and the prefix lookup, yet still fail in the address table. Such a packet must leave with no edits at all, although the forwarding rewrite values were nearly selected. The bench reaches it by loading a prefix entry whose next hop has no address entry, and sends packets that match it from two different input ports. Longest-prefix choice is driven by three nested prefixes, so each length wins once. A throttled `out_rdy` pattern stalls the rewrite mid-header.

// File: rtl/fhp_pkg.sv
package fhp_pkg;

  localparam logic [7:0]  CTRL_INQ_HDR = 8'hff;
  localparam logic [15:0] ETYPE_IPV4   = 16'h0800;
  localparam logic [7:0]  VIHL_PLAIN   = 8'h45;

  typedef enum logic [1:0] {
    ST_RECV    = 2'd0,
    ST_ROUTE   = 2'd1,
    ST_RESOLVE = 2'd2,
    ST_SEND    = 2'd3
  } fhp_state_e;

  // End-around-carry fold of a wide ones'-complement accumulator.
  function automatic logic [15:0] ones_fold(input logic [31:0] s);
    logic [31:0] t;
    t = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    t = {16'h0, t[15:0]} + {16'h0, t[31:16]};
    return t[15:0];
  endfunction

  // Incremental update of the checksum when the TTL byte drops by one.
  function automatic logic [15:0] csum_after_ttl_dec(input logic [15:0] hc,
                                                     input logic [7:0]  ttl,
                                                     input logic [7:0]  proto);
    logic [15:0] old_hw;
    logic [15:0] new_hw;
    logic [31:0] acc;
    old_hw = {ttl, proto};
    new_hw = {ttl - 8'd1, proto};
    acc    = {16'h0, ~hc} + {16'h0, ~old_hw} + {16'h0, new_hw};
    return ~ones_fold(acc);
  endfunction

endpackage

// File: rtl/fhp_route_table.sv
module fhp_route_table #(
  parameter int ENTRIES = 8,
  parameter int PORT_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic                       wr_valid,
  input  logic [31:0]                wr_prefix,
  input  logic [5:0]                 wr_len,
  input  logic [31:0]                wr_nh,
  input  logic [PORT_W-1:0]          wr_port,
  input  logic [31:0]                key,
  output logic                       hit,
  output logic [31:0]                nh,
  output logic [PORT_W-1:0]          port
);

  logic              t_valid [ENTRIES];
  logic [31:0]       t_pfx   [ENTRIES];
  logic [31:0]       t_mask  [ENTRIES];
  logic [5:0]        t_len   [ENTRIES];
  logic [31:0]       t_nh    [ENTRIES];
  logic [PORT_W-1:0] t_port  [ENTRIES];

  logic [31:0] wr_mask;
  assign wr_mask = (wr_len == 6'd0) ? 32'h0 : (32'hffff_ffff << (6'd32 - wr_len));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) t_valid[i] <= 1'b0;
    end else if (wr_en) begin
      t_valid[wr_idx] <= wr_valid;
      t_pfx[wr_idx]   <= wr_prefix & wr_mask;
      t_mask[wr_idx]  <= wr_mask;
      t_len[wr_idx]   <= wr_len;
      t_nh[wr_idx]    <= wr_nh;
      t_port[wr_idx]  <= wr_port;
    end
  end

  // Priority on prefix length: a later entry only replaces a strictly longer match.
  logic [5:0] best_len;
  always_comb begin
    hit      = 1'b0;
    best_len = 6'd0;
    nh       = 32'h0;
    port     = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (t_valid[i] && ((key & t_mask[i]) == t_pfx[i]) && (!hit || (t_len[i] > best_len))) begin
        hit      = 1'b1;
        best_len = t_len[i];
        nh       = t_nh[i];
        port     = t_port[i];
      end
    end
  end

  a_r4_len_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_len <= 6'd32));

endmodule

// File: rtl/fhp_nbr_table.sv
module fhp_nbr_table #(
  parameter int ENTRIES = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic                       wr_valid,
  input  logic [31:0]                wr_ip,
  input  logic [47:0]                wr_mac,
  input  logic [31:0]                key,
  output logic                       hit,
  output logic [47:0]                mac
);

  logic        t_valid [ENTRIES];
  logic [31:0] t_ip    [ENTRIES];
  logic [47:0] t_mac   [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) t_valid[i] <= 1'b0;
    end else if (wr_en) begin
      t_valid[wr_idx] <= wr_valid;
      t_ip[wr_idx]    <= wr_ip;
      t_mac[wr_idx]   <= wr_mac;
    end
  end

  // Exact match; the lowest matching index wins.
  always_comb begin
    hit = 1'b0;
    mac = 48'h0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (t_valid[i] && (t_ip[i] == key)) begin
        hit = 1'b1;
        mac = t_mac[i];
      end
    end
  end

endmodule

// File: rtl/fhp_pkt_buf.sv
module fhp_pkt_buf #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 72
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [WIDTH-1:0]         rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/ipv4_fwd_hdr_proc.sv
module ipv4_fwd_hdr_proc
  import fhp_pkg::*;
#(
  parameter int NUM_MAC   = 4,
  parameter int RT_SIZE   = 8,
  parameter int NB_SIZE   = 8,
  parameter int BUF_DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [63:0]                  in_data,
  input  logic [7:0]                   in_ctrl,
  input  logic                         in_wr,
  output logic                         in_rdy,
  output logic [63:0]                  out_data,
  output logic [7:0]                   out_ctrl,
  output logic                         out_wr,
  input  logic                         out_rdy,
  input  logic                         rt_we,
  input  logic [$clog2(RT_SIZE)-1:0]   rt_idx,
  input  logic                         rt_valid,
  input  logic [31:0]                  rt_prefix,
  input  logic [5:0]                   rt_len,
  input  logic [31:0]                  rt_nh,
  input  logic [$clog2(NUM_MAC)-1:0]   rt_port,
  input  logic                         nb_we,
  input  logic [$clog2(NB_SIZE)-1:0]   nb_idx,
  input  logic                         nb_valid,
  input  logic [31:0]                  nb_ip,
  input  logic [47:0]                  nb_mac,
  input  logic                         pm_we,
  input  logic [$clog2(NUM_MAC)-1:0]   pm_idx,
  input  logic [47:0]                  pm_mac
);

  localparam int NPORT = 2 * NUM_MAC;
  localparam int PW    = $clog2(NPORT);
  localparam int MW    = $clog2(NUM_MAC);
  localparam int BW    = $clog2(BUF_DEPTH);
  localparam int HDR_WORDS = 5;

  fhp_state_e state;

  // ---------------- receive side bookkeeping ----------------
  logic [BW:0]   wptr, rptr, last_idx, hdr_idx, d0_idx;
  logic          hdr_seen, data_seen, in_rdy_q;
  logic [2:0]    dcnt;
  logic [63:0]   hw [8];
  logic [PW-1:0] in_port;
  logic [47:0]   pmac [NUM_MAC];

  logic accept;
  assign accept = in_wr && in_rdy_q;
  assign in_rdy = in_rdy_q;

  fhp_pkt_buf #(.DEPTH(BUF_DEPTH), .WIDTH(72)) u_buf (
    .clk     (clk),
    .wr_en   (accept),
    .wr_addr (wptr[BW-1:0]),
    .wr_data ({in_ctrl, in_data}),
    .rd_addr (rptr[BW-1:0]),
    .rd_data (rd_word)
  );
  logic [71:0] rd_word;

  always_ff @(posedge clk) begin
    if (pm_we) pmac[pm_idx] <= pm_mac;
  end

  // ---------------- header field extraction ----------------
  logic [47:0] eth_dst;
  logic [15:0] eth_type, hdr_cs;
  logic [7:0]  vihl, ttl, proto;
  logic [31:0] dst_ip, hsum;
  logic [MW-1:0] in_mac_idx;
  logic        from_cpu, cs_ok, parse_exc;

  assign eth_dst    = hw[0][63:16];
  assign eth_type   = hw[1][31:16];
  assign vihl       = hw[1][15:8];
  assign ttl        = hw[2][15:8];
  assign proto      = hw[2][7:0];
  assign hdr_cs     = hw[3][63:48];
  assign dst_ip     = {hw[3][15:0], hw[4][63:48]};
  assign from_cpu   = in_port[0];
  assign in_mac_idx = in_port[PW-1:1];

  assign hsum = 32'(hw[1][15:0])  + 32'(hw[2][63:48]) + 32'(hw[2][47:32]) +
                32'(hw[2][31:16]) + 32'(hw[2][15:0])  + 32'(hw[3][63:48]) +
                32'(hw[3][47:32]) + 32'(hw[3][31:16]) + 32'(hw[3][15:0])  +
                32'(hw[4][63:48]);
  assign cs_ok = (ones_fold(hsum) == 16'hffff);

  assign parse_exc = (eth_dst != pmac[in_mac_idx]) || (eth_type != ETYPE_IPV4) ||
                     (vihl != VIHL_PLAIN) || !cs_ok || (ttl <= 8'd1);

  // ---------------- lookups ----------------
  logic          rt_hit, nb_hit;
  logic [31:0]   rt_nh_o;
  logic [MW-1:0] rt_port_o;
  logic [47:0]   nb_mac_o;
  logic          exc_r;
  logic [31:0]   nh_r;
  logic [MW-1:0] port_r;

  fhp_route_table #(.ENTRIES(RT_SIZE), .PORT_W(MW)) u_rt (
    .clk (clk), .rst (rst),
    .wr_en (rt_we), .wr_idx (rt_idx), .wr_valid (rt_valid),
    .wr_prefix (rt_prefix), .wr_len (rt_len), .wr_nh (rt_nh), .wr_port (rt_port),
    .key (dst_ip), .hit (rt_hit), .nh (rt_nh_o), .port (rt_port_o)
  );

  fhp_nbr_table #(.ENTRIES(NB_SIZE)) u_nb (
    .clk (clk), .rst (rst),
    .wr_en (nb_we), .wr_idx (nb_idx), .wr_valid (nb_valid),
    .wr_ip (nb_ip), .wr_mac (nb_mac),
    .key (nh_r), .hit (nb_hit), .mac (nb_mac_o)
  );

  // ---------------- decision registers ----------------
  logic [NPORT-1:0] oh_r;
  logic             fwd_q;
  logic [47:0]      new_dmac, new_smac;
  logic [7:0]       new_ttl;
  logic [15:0]      new_cs;

  // ---------------- transmit edit ----------------
  logic [BW:0]  d1_idx, d2_idx, d3_idx;
  logic [63:0]  ed;
  assign d1_idx = d0_idx + 1'b1;
  assign d2_idx = d0_idx + 2'd2;
  assign d3_idx = d0_idx + 2'd3;

  always_comb begin
    ed = rd_word[63:0];
    if (hdr_seen && (rptr == hdr_idx)) ed[63:48] = 16'(oh_r);
    if (fwd_q) begin
      if (rptr == d0_idx)      ed = {new_dmac, new_smac[47:32]};
      else if (rptr == d1_idx) ed[63:32] = new_smac[31:0];
      else if (rptr == d2_idx) ed[15:8] = new_ttl;
      else if (rptr == d3_idx) ed[63:48] = new_cs;
    end
  end

  // ---------------- control ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_RECV;
      in_rdy_q  <= 1'b1;
      wptr      <= '0;
      rptr      <= '0;
      last_idx  <= '0;
      hdr_idx   <= '0;
      d0_idx    <= '0;
      hdr_seen  <= 1'b0;
      data_seen <= 1'b0;
      dcnt      <= '0;
      in_port   <= '0;
      exc_r     <= 1'b0;
      nh_r      <= '0;
      port_r    <= '0;
      oh_r      <= '0;
      fwd_q     <= 1'b0;
      new_dmac  <= '0;
      new_smac  <= '0;
      new_ttl   <= '0;
      new_cs    <= '0;
      out_data  <= '0;
      out_ctrl  <= '0;
      out_wr    <= 1'b0;
    end else begin
      out_wr <= 1'b0;
      case (state)
        ST_RECV: begin
          if (accept) begin
            wptr <= wptr + 1'b1;
            if (!data_seen && (in_ctrl != 8'h00)) begin
              if (in_ctrl == CTRL_INQ_HDR) begin
                hdr_seen <= 1'b1;
                hdr_idx  <= wptr;
                in_port  <= in_data[16 +: PW];
              end
            end else begin
              if (dcnt < 3'(HDR_WORDS)) begin
                hw[dcnt] <= in_data;
                dcnt     <= dcnt + 1'b1;
              end
              if (!data_seen) begin
                data_seen <= 1'b1;
                d0_idx    <= wptr;
              end else if (in_ctrl != 8'h00) begin
                last_idx <= wptr;
                in_rdy_q <= 1'b0;
                state    <= ST_ROUTE;
              end
            end
          end
        end
        ST_ROUTE: begin
          exc_r  <= parse_exc || !rt_hit;
          nh_r   <= (rt_nh_o == 32'h0) ? dst_ip : rt_nh_o;
          port_r <= rt_port_o;
          state  <= ST_RESOLVE;
        end
        ST_RESOLVE: begin
          oh_r <= '0;
          if (from_cpu) begin
            oh_r[{in_mac_idx, 1'b0}] <= 1'b1;
            fwd_q <= 1'b0;
          end else if (exc_r || !nb_hit) begin
            oh_r[{in_mac_idx, 1'b1}] <= 1'b1;
            fwd_q <= 1'b0;
          end else begin
            oh_r[{port_r, 1'b0}] <= 1'b1;
            fwd_q <= 1'b1;
          end
          new_dmac <= nb_mac_o;
          new_smac <= pmac[port_r];
          new_ttl  <= ttl - 8'd1;
          new_cs   <= csum_after_ttl_dec(hdr_cs, ttl, proto);
          rptr     <= '0;
          state    <= ST_SEND;
        end
        ST_SEND: begin
          if (out_rdy) begin
            out_data <= ed;
            out_ctrl <= rd_word[71:64];
            out_wr   <= 1'b1;
            rptr     <= rptr + 1'b1;
            if (rptr == last_idx) begin
              state     <= ST_RECV;
              in_rdy_q  <= 1'b1;
              wptr      <= '0;
              dcnt      <= '0;
              hdr_seen  <= 1'b0;
              data_seen <= 1'b0;
            end
          end
        end
        default: state <= ST_RECV;
      endcase
    end
  end

  // ---------------- assertions ----------------
  a_r13_out_permit: assert property (@(posedge clk) disable iff (rst)
    out_wr |-> $past(out_rdy));

  a_r13_in_permit: assert property (@(posedge clk) disable iff (rst)
    in_wr |-> in_rdy);

  a_r3_single_port: assert property (@(posedge clk) disable iff (rst)
    (out_wr && (out_ctrl == CTRL_INQ_HDR)) |-> ($countones(out_data[63:48]) == 1));

  a_r2_no_overrun: assert property (@(posedge clk) disable iff (rst)
    accept |-> (wptr < (BW+1)'(BUF_DEPTH)));

  a_r8_ttl_exception: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_SEND) && !from_cpu && (ttl <= 8'd1)) |-> (oh_r[{in_mac_idx, 1'b1}] && !fwd_q));

  a_r12_cpu_source: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_SEND) && from_cpu) |-> (oh_r[{in_mac_idx, 1'b0}] && !fwd_q));

endmodule

// File: tb/ipv4_fwd_hdr_proc_tb_top.sv
module ipv4_fwd_hdr_proc_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] in_data = '0;
  logic [7:0]  in_ctrl = '0;
  logic        in_wr = 1'b0;
  logic        in_rdy;
  logic [63:0] out_data;
  logic [7:0]  out_ctrl;
  logic        out_wr;
  logic        out_rdy = 1'b1;
  logic        rt_we = 1'b0, rt_valid = 1'b0;
  logic [2:0]  rt_idx = '0;
  logic [31:0] rt_prefix = '0, rt_nh = '0;
  logic [5:0]  rt_len = '0;
  logic [1:0]  rt_port = '0;
  logic        nb_we = 1'b0, nb_valid = 1'b0;
  logic [2:0]  nb_idx = '0;
  logic [31:0] nb_ip = '0;
  logic [47:0] nb_mac = '0;
  logic        pm_we = 1'b0;
  logic [1:0]  pm_idx = '0;
  logic [47:0] pm_mac = '0;

  always #4 clk = ~clk;

  ipv4_fwd_hdr_proc dut_i (
    .clk (clk), .rst (rst),
    .in_data (in_data), .in_ctrl (in_ctrl), .in_wr (in_wr), .in_rdy (in_rdy),
    .out_data (out_data), .out_ctrl (out_ctrl), .out_wr (out_wr), .out_rdy (out_rdy),
    .rt_we (rt_we), .rt_idx (rt_idx), .rt_valid (rt_valid), .rt_prefix (rt_prefix),
    .rt_len (rt_len), .rt_nh (rt_nh), .rt_port (rt_port),
    .nb_we (nb_we), .nb_idx (nb_idx), .nb_valid (nb_valid), .nb_ip (nb_ip), .nb_mac (nb_mac),
    .pm_we (pm_we), .pm_idx (pm_idx), .pm_mac (pm_mac)
  );

  int checks = 0;
  int errors = 0;

  localparam logic [47:0] SRC_MAC = 48'h0a_bb_cc_dd_ee_01;
  localparam logic [47:0] NB_A1 = 48'h00_11_22_33_44_a1;
  localparam logic [47:0] NB_A2 = 48'h00_11_22_33_44_a2;
  localparam logic [47:0] NB_A3 = 48'h00_11_22_33_44_a3;

  function automatic logic [47:0] pmac_of(input int p);
    return 48'h02_00_00_00_00_10 + 48'(p);
  endfunction

  // ---------------- capture monitor ----------------
  logic [63:0] cap_d [16];
  logic [7:0]  cap_c [16];
  int          ncap = 0;
  int          rdy_viol = 0;
  logic        rdy_seen = 1'b1;
  bit          bp_mode = 1'b0;
  int          bp_cnt = 0;

  always @(negedge clk) begin
    if (out_wr) begin
      if (ncap < 16) begin
        cap_d[ncap] = out_data;
        cap_c[ncap] = out_ctrl;
      end
      ncap++;
      if (!rdy_seen) rdy_viol++;
    end
    rdy_seen = out_rdy;
  end

  always @(posedge clk) begin
    #2;
    bp_cnt++;
    out_rdy = bp_mode ? ((bp_cnt % 3) != 0) : 1'b1;
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- stimulus helpers ----------------
  logic [63:0] pd [8];
  logic [7:0]  pc [8];
  int          plen;

  function automatic logic [15:0] ip_sum(input logic [63:0] w1, input logic [63:0] w2,
                                         input logic [63:0] w3, input logic [63:0] w4);
    logic [31:0] s;
    s = 32'(w1[15:0]) + 32'(w2[63:48]) + 32'(w2[47:32]) + 32'(w2[31:16]) + 32'(w2[15:0]) +
        32'(w3[63:48]) + 32'(w3[47:32]) + 32'(w3[31:16]) + 32'(w3[15:0]) + 32'(w4[63:48]);
    s = 32'(s[15:0]) + 32'(s[31:16]);
    s = 32'(s[15:0]) + 32'(s[31:16]);
    return s[15:0];
  endfunction

  task automatic build(input int port, input logic [47:0] dmac, input logic [7:0] ttl,
                       input logic [31:0] dip, input logic [7:0] vihl, input bit corrupt);
    logic [63:0] w1, w2, w3, w4;
    logic [15:0] cs;
    w1 = {SRC_MAC[31:0], 16'h0800, vihl, 8'h00};
    w2 = {16'd46, 16'h1234, 16'h4000, ttl, 8'h11};
    w3 = {16'h0000, 32'hc0a8_0164, dip[31:16]};
    w4 = {dip[15:0], 48'hdead_beef_0001};
    cs = ~ip_sum(w1, w2, w3, w4);
    if (corrupt) cs = cs ^ 16'h0010;
    w3[63:48] = cs;
    pd[0] = {32'h0, 16'(port), 16'd48};  pc[0] = 8'hff;
    pd[1] = {dmac, SRC_MAC[47:32]};     pc[1] = 8'h00;
    pd[2] = w1;                         pc[2] = 8'h00;
    pd[3] = w2;                         pc[3] = 8'h00;
    pd[4] = w3;                         pc[4] = 8'h00;
    pd[5] = w4;                         pc[5] = 8'h00;
    pd[6] = 64'h0102_0304_0506_0708;    pc[6] = 8'h80;
    plen = 7;
  endtask

  // Sends pd/pc, collects the output and compares it with the expected packet.
  task automatic run(input string name, input string req, input int oh_bit, input bit fwd,
                     input logic [47:0] dm, input logic [47:0] sm);
    logic [63:0] ex [8];
    logic [15:0] cs;
    int bad;
    for (int i = 0; i < plen; i++) ex[i] = pd[i];
    ex[0][63:48] = 16'(1 << oh_bit);
    if (fwd) begin
      ex[1] = {dm, sm[47:32]};
      ex[2][63:32] = sm[31:0];
      ex[3][15:8] = pd[3][15:8] - 8'd1;
      ex[4][63:48] = 16'h0;
      cs = ~ip_sum(ex[2], ex[3], ex[4], ex[5]);
      ex[4][63:48] = cs;
    end
    ncap = 0;
    for (int i = 0; i < plen; i++) begin
      @(negedge clk);
      while (!in_rdy) @(negedge clk);
      in_wr = 1'b1; in_data = pd[i]; in_ctrl = pc[i];
    end
    @(negedge clk);
    in_wr = 1'b0; in_ctrl = 8'h00;
    for (int t = 0; t < 400 && ncap < plen; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(cap_d[0][63:48] == 16'(1 << oh_bit), req, {name, " output port"},
          64'(cap_d[0][63:48]), 64'(16'(1 << oh_bit)));
    bad = -1;
    for (int i = plen - 1; i >= 0; i--)
      if (cap_d[i] !== ex[i] || cap_c[i] !== pc[i]) bad = i;
    if (ncap != plen)
      check(1'b0, "R2", {name, " word count"}, 64'(ncap), 64'(plen));
    else if (bad >= 0)
      check(1'b0, req, $sformatf("%s word %0d", name, bad), cap_d[bad], ex[bad]);
    else
      check(1'b1, req, {name, " contents"}, 64'h0, 64'h0);
  endtask

  task automatic rt_load(input int idx, input logic [31:0] pfx, input int len,
                         input logic [31:0] nh, input int port);
    @(negedge clk);
    rt_we = 1'b1; rt_idx = 3'(idx); rt_valid = 1'b1; rt_prefix = pfx;
    rt_len = 6'(len); rt_nh = nh; rt_port = 2'(port);
    @(negedge clk);
    rt_we = 1'b0;
  endtask

  task automatic nb_load(input int idx, input logic [31:0] ip, input logic [47:0] mac);
    @(negedge clk);
    nb_we = 1'b1; nb_idx = 3'(idx); nb_valid = 1'b1; nb_ip = ip; nb_mac = mac;
    @(negedge clk);
    nb_we = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    repeat (2) @(negedge clk);
    check(in_rdy == 1'b1, "R1", "in_rdy after reset", 64'(in_rdy), 64'd1);
    check(out_wr == 1'b0, "R1", "out_wr after reset", 64'(out_wr), 64'd0);
  endtask

  task automatic t_longest_prefix;
    build(0, pmac_of(0), 8'd64, 32'h0a01_0207, 8'h45, 1'b0);
    run("slash24", "R4", 6, 1'b1, NB_A2, pmac_of(3));     // R4 R6 R7
    build(0, pmac_of(0), 8'd64, 32'h0a01_0909, 8'h45, 1'b0);
    run("slash16", "R4", 4, 1'b1, NB_A1, pmac_of(2));
  endtask

  task automatic t_direct;
    build(2, pmac_of(1), 8'd30, 32'h0a05_0505, 8'h45, 1'b0);
    run("direct", "R5", 2, 1'b1, NB_A3, pmac_of(1));
  endtask

  task automatic t_ttl_edge;
    build(2, pmac_of(1), 8'd2, 32'h0a01_02c8, 8'h45, 1'b0);
    run("ttl2", "R7", 6, 1'b1, NB_A2, pmac_of(3));
    build(2, pmac_of(1), 8'd1, 32'h0a01_0207, 8'h45, 1'b0);
    run("ttl1", "R8", 3, 1'b0, '0, '0);
    build(0, pmac_of(0), 8'd0, 32'h0a01_0207, 8'h45, 1'b0);
    run("ttl0", "R8", 1, 1'b0, '0, '0);
  endtask

  task automatic t_bad_header;
    build(4, pmac_of(2), 8'd64, 32'h0a01_0207, 8'h45, 1'b1);
    run("bad_csum", "R9", 5, 1'b0, '0, '0);
    build(0, pmac_of(0), 8'd64, 32'h0a01_0207, 8'h46, 1'b0);
    run("options", "R9", 1, 1'b0, '0, '0);
  endtask

  task automatic t_wrong_mac;
    build(0, pmac_of(1), 8'd64, 32'h0a01_0207, 8'h45, 1'b0);
    run("dst_mac", "R10", 1, 1'b0, '0, '0);
  endtask

  task automatic t_misses;
    build(0, pmac_of(0), 8'd64, 32'h1e00_0001, 8'h45, 1'b0);
    run("route_miss", "R11", 1, 1'b0, '0, '0);
    build(0, pmac_of(0), 8'd64, 32'h1401_0101, 8'h45, 1'b0);
    run("nbr_miss", "R11", 1, 1'b0, '0, '0);
    build(6, pmac_of(3), 8'd64, 32'h1401_0101, 8'h45, 1'b0);
    run("nbr_miss_p6", "R11", 7, 1'b0, '0, '0);
  endtask

  task automatic t_from_cpu;
    build(5, 48'hffff_ffff_ffff, 8'd0, 32'h0a01_0207, 8'h47, 1'b1);
    run("cpu_src", "R12", 4, 1'b0, '0, '0);
  endtask

  task automatic t_backpressure;
    bp_mode = 1'b1;
    rdy_viol = 0;
    build(0, pmac_of(0), 8'd64, 32'h0a01_0207, 8'h45, 1'b0);
    run("throttled", "R13", 6, 1'b1, NB_A2, pmac_of(3));
    bp_mode = 1'b0;
    check(rdy_viol == 0, "R13", "words without permit", 64'(rdy_viol), 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      pm_we = 1'b1; pm_idx = 2'(p); pm_mac = pmac_of(p);
    end
    @(negedge clk);
    pm_we = 1'b0;
    rt_load(0, 32'h0a00_0000, 8,  32'h0,         1);
    rt_load(1, 32'h0a01_0000, 16, 32'hc0a8_0901, 2);
    rt_load(2, 32'h0a01_0200, 24, 32'hc0a8_0902, 3);
    rt_load(3, 32'h1400_0000, 8,  32'hc0a8_09aa, 0);
    nb_load(0, 32'hc0a8_0901, NB_A1);
    nb_load(1, 32'hc0a8_0902, NB_A2);
    nb_load(2, 32'h0a05_0505, NB_A3);
    t_longest_prefix();
    t_direct();
    t_ttl_edge();
    t_bad_header();
    t_wrong_mac();
    t_misses();
    t_from_cpu();
    t_backpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule